// File: doc/BRIEF.md
# Interrupt Stack Frame Sequencer

This block builds and unwinds the interrupt stack frame for a processor core that can run tasks in a virtual-8086 mode. When an interrupt or exception is taken, it issues an ordered run of 32-bit stack writes on the privileged stack. If the interrupted task was running in V86 mode, four data-segment selectors go onto the stack ahead of the usual frame, and those four registers are then cleared to null. When the handler returns, the block issues an ordered run of stack reads. It loads each word into the register outputs. After it has read back the flags word, it decides whether four more segment words must be popped.

The caller asserts a one-cycle `start_entry` or `start_iret` request. It presents the current register values, the privileged stack pointer and selector, and the handler target. The block then drives a single outstanding memory request at a time, and each request completes with an acknowledge or an error. A `done` pulse marks a completed sequence. An error aborts the sequence through `fault`, and the register outputs are left as they were.

Top module: `intr_frame_seq`

## Requirements
- R1: After reset, `done`, `fault` and `mem_req` are low and every register output is zero.
- R2: An entry with `from_vm`=1 writes, at strictly descending addresses that start 4 below `k_esp`, the words GS, FS, DS, ES, SS, ESP, EFLAGS, CS, EIP. The stack pointer drops by 4 before each write, and selectors are zero-extended to 32 bits.
- R3: On entry, `err_code` is written as one extra word after EIP, 4 bytes below it, only when `has_err`=1.
- R4: An entry with `from_vm`=0 writes no segment words. It starts with SS at `k_esp`-4 and then follows the same order as R2.
- R5: When an entry completes, the outputs are set as follows. `o_eip`=`h_eip`, `o_cs`=`h_cs`, `o_ss`=`k_ss`. `o_esp` is the address of the last word written. `o_eflags` is the pushed flags with bit 17 (VM) cleared, and `o_vm`=0. `o_es`/`o_ds`/`o_fs`/`o_gs` are zero after a V86 entry and equal the current inputs otherwise.
- R6: An IRET reads EIP, CS, EFLAGS, ESP, SS at ascending addresses starting at `k_esp`, with the pointer rising by 4 after each read. The popped values go to `o_eip`, `o_cs`, `o_eflags`, `o_esp`, `o_ss`, and selectors keep only the low 16 bits.
- R7: If bit 17 of the popped EFLAGS is set, the IRET reads four more words, ES, DS, FS, GS, loads them into the segment outputs and sets `o_vm`=1. Otherwise only five reads occur, the segment outputs take the current inputs, and `o_vm`=0.
- R8: Only one request is outstanding at a time. While it is unanswered, `mem_req` stays high with stable address, direction and write data, and the next access starts only after `mem_ack`.
- R9: `done` is a one-cycle pulse in the cycle after the final acknowledge.
- R10: `mem_err` on a request ends the sequence. `fault` pulses for one cycle, `done` does not occur, no further request is issued, and no register output changes.
- R11: Start requests are ignored while a sequence is running. If `start_entry` and `start_iret` arrive in the same idle cycle, the entry is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_entry | input | 1 | Begin an interrupt/exception entry frame |
| start_iret | input | 1 | Begin a return-from-interrupt unwind |
| from_vm | input | 1 | Interrupted task was in V86 mode (entry) |
| has_err | input | 1 | Exception supplies an error code (entry) |
| err_code | input | 32 | Error code word |
| cur_eip | input | 32 | Current instruction pointer |
| cur_eflags | input | 32 | Current flags |
| cur_esp | input | 32 | Current task stack pointer |
| cur_cs | input | 16 | Current code selector |
| cur_ss | input | 16 | Current stack selector |
| cur_es | input | 16 | Current ES selector |
| cur_ds | input | 16 | Current DS selector |
| cur_fs | input | 16 | Current FS selector |
| cur_gs | input | 16 | Current GS selector |
| k_ss | input | 16 | Privileged stack selector |
| k_esp | input | 32 | Privileged stack pointer at start |
| h_cs | input | 16 | Handler code selector |
| h_eip | input | 32 | Handler entry point |
| mem_req | output | 1 | Stack access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Stack address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done | output | 1 | Sequence completed |
| fault | output | 1 | Sequence aborted |
| o_eip | output | 32 | Resulting instruction pointer |
| o_eflags | output | 32 | Resulting flags |
| o_esp | output | 32 | Resulting stack pointer |
| o_cs | output | 16 | Resulting code selector |
| o_ss | output | 16 | Resulting stack selector |
| o_es | output | 16 | Resulting ES selector |
| o_ds | output | 16 | Resulting DS selector |
| o_fs | output | 16 | Resulting FS selector |
| o_gs | output | 16 | Resulting GS selector |
| o_vm | output | 1 | Resulting V86 mode flag |

## Verification
Two collisions can happen in the same cycle. One is an entry request meeting a return request. The other is a new request arriving while a sequence is still in flight. The bench raises `start_entry` and `start_iret` together on one idle edge. The scoreboard must then see exactly the entry's write stream and no reads. In a separate case, `start_iret` is pulsed midway through an entry, and after `done` the expectation queue has to be empty, with the outputs matching the entry alone.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
    localparam int SLOT_N = 10;

    typedef enum logic [3:0] {
        SL_GS  = 4'd0,
        SL_FS  = 4'd1,
        SL_DS  = 4'd2,
        SL_ES  = 4'd3,
        SL_SS  = 4'd4,
        SL_ESP = 4'd5,
        SL_EFL = 4'd6,
        SL_CS  = 4'd7,
        SL_EIP = 4'd8,
        SL_ERR = 4'd9
    } slot_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/ifs_slot_map.sv
module ifs_slot_map
    import ifs_pkg::*;
(
    input  logic       is_pop,
    input  logic [3:0] step,
    output slot_e      slot
);
    // push walks slots upward from GS; pop walks downward from EIP
    always_comb begin
        if (is_pop) slot = slot_e'(4'(SL_EIP) - step);
        else        slot = slot_e'(step);
    end
endmodule

// File: rtl/ifs_sp_step.sv
module ifs_sp_step #(
    parameter int DW = 32
) (
    input  logic          is_pop,
    input  logic [DW-1:0] sp,
    output logic [DW-1:0] addr,
    output logic [DW-1:0] sp_nxt
);
    localparam logic [DW-1:0] WORD_BYTES = DW'(DW / 8);

    always_comb begin
        if (is_pop) begin
            addr   = sp;
            sp_nxt = sp + WORD_BYTES;
        end else begin
            addr   = sp - WORD_BYTES;
            sp_nxt = sp - WORD_BYTES;
        end
    end
endmodule

// File: rtl/ifs_frame_io.sv
module ifs_frame_io
    import ifs_pkg::*;
#(
    parameter int DW    = 32,
    parameter int SEL_W = 16
) (
    input  slot_e                     slot,
    input  logic [SLOT_N-1:0][DW-1:0] frame,
    input  logic [DW-1:0]             rdata,
    output logic [DW-1:0]             wdata,
    output logic [DW-1:0]             ldval
);
    localparam int PAD_W = DW - SEL_W;

    logic is_sel;

    always_comb begin
        is_sel = (slot == SL_GS) || (slot == SL_FS) || (slot == SL_DS) ||
                 (slot == SL_ES) || (slot == SL_SS) || (slot == SL_CS);
        wdata  = frame[slot];
        ldval  = is_sel ? {{PAD_W{1'b0}}, rdata[SEL_W-1:0]} : rdata;
    end
endmodule

// File: rtl/intr_frame_seq.sv
module intr_frame_seq
    import ifs_pkg::*;
#(
    parameter int DW     = 32,
    parameter int SEL_W  = 16,
    parameter int VM_BIT = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_entry,
    input  logic             start_iret,
    input  logic             from_vm,
    input  logic             has_err,
    input  logic [DW-1:0]    err_code,
    input  logic [DW-1:0]    cur_eip,
    input  logic [DW-1:0]    cur_eflags,
    input  logic [DW-1:0]    cur_esp,
    input  logic [SEL_W-1:0] cur_cs,
    input  logic [SEL_W-1:0] cur_ss,
    input  logic [SEL_W-1:0] cur_es,
    input  logic [SEL_W-1:0] cur_ds,
    input  logic [SEL_W-1:0] cur_fs,
    input  logic [SEL_W-1:0] cur_gs,
    input  logic [SEL_W-1:0] k_ss,
    input  logic [DW-1:0]    k_esp,
    input  logic [SEL_W-1:0] h_cs,
    input  logic [DW-1:0]    h_eip,
    output logic             mem_req,
    output logic             mem_we,
    output logic [DW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic             mem_err,
    input  logic [DW-1:0]    mem_rdata,
    output logic             done,
    output logic             fault,
    output logic [DW-1:0]    o_eip,
    output logic [DW-1:0]    o_eflags,
    output logic [DW-1:0]    o_esp,
    output logic [SEL_W-1:0] o_cs,
    output logic [SEL_W-1:0] o_ss,
    output logic [SEL_W-1:0] o_es,
    output logic [SEL_W-1:0] o_ds,
    output logic [SEL_W-1:0] o_fs,
    output logic [SEL_W-1:0] o_gs,
    output logic             o_vm
);
    localparam int         PAD_W      = DW - SEL_W;
    localparam logic [3:0] FIRST_SEG  = 4'(SL_GS);
    localparam logic [3:0] FIRST_BASE = 4'(SL_SS);
    localparam logic [3:0] POP_BASE_N = 4'd4;
    localparam logic [3:0] POP_FULL_N = 4'd8;

    typedef struct packed {
        phase_e                    ph;
        logic                      pop;
        logic                      ent_vm;
        logic [3:0]                step;
        logic [3:0]                last;
        logic [DW-1:0]             sp;
        logic [SLOT_N-1:0][DW-1:0] frame;
        logic [SEL_W-1:0]          hcs;
        logic [SEL_W-1:0]          kss;
        logic [DW-1:0]             heip;
        logic                      done;
        logic                      fault;
        logic [DW-1:0]             eip;
        logic [DW-1:0]             efl;
        logic [DW-1:0]             esp;
        logic [SEL_W-1:0]          cs;
        logic [SEL_W-1:0]          ss;
        logic [SEL_W-1:0]          es;
        logic [SEL_W-1:0]          ds;
        logic [SEL_W-1:0]          fs;
        logic [SEL_W-1:0]          gs;
        logic                      vm;
    } seq_t;

    seq_t q, d;

    slot_e         cur_slot;
    logic [DW-1:0] acc_addr, sp_nxt, ld_val, wr_val;

    function automatic logic [DW-1:0] zx(input logic [SEL_W-1:0] s);
        return {{PAD_W{1'b0}}, s};
    endfunction

    ifs_slot_map u_map (
        .is_pop (q.pop),
        .step   (q.step),
        .slot   (cur_slot)
    );

    ifs_sp_step #(.DW(DW)) u_sp (
        .is_pop (q.pop),
        .sp     (q.sp),
        .addr   (acc_addr),
        .sp_nxt (sp_nxt)
    );

    ifs_frame_io #(.DW(DW), .SEL_W(SEL_W)) u_io (
        .slot  (cur_slot),
        .frame (q.frame),
        .rdata (mem_rdata),
        .wdata (wr_val),
        .ldval (ld_val)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.fault = 1'b0;
        unique case (q.ph)
            ST_IDLE: begin
                if (start_entry || start_iret) begin
                    d.ph                = ST_RUN;
                    d.sp                = k_esp;
                    d.frame[SL_GS]      = zx(cur_gs);
                    d.frame[SL_FS]      = zx(cur_fs);
                    d.frame[SL_DS]      = zx(cur_ds);
                    d.frame[SL_ES]      = zx(cur_es);
                    d.frame[SL_SS]      = zx(cur_ss);
                    d.frame[SL_ESP]     = cur_esp;
                    d.frame[SL_EFL]     = cur_eflags;
                    d.frame[SL_CS]      = zx(cur_cs);
                    d.frame[SL_EIP]     = cur_eip;
                    d.frame[SL_ERR]     = err_code;
                    d.hcs               = h_cs;
                    d.kss               = k_ss;
                    d.heip              = h_eip;
                    if (start_entry) begin
                        d.pop    = 1'b0;
                        d.ent_vm = from_vm;
                        d.step   = from_vm ? FIRST_SEG : FIRST_BASE;
                        d.last   = has_err ? 4'(SL_ERR) : 4'(SL_EIP);
                    end else begin
                        d.pop    = 1'b1;
                        d.ent_vm = 1'b0;
                        d.step   = 4'd0;
                        d.last   = POP_BASE_N;
                    end
                end
            end
            ST_RUN: begin
                if (mem_err) begin
                    d.ph    = ST_IDLE;
                    d.fault = 1'b1;
                end else if (mem_ack) begin
                    d.sp = sp_nxt;
                    if (q.pop) begin
                        d.frame[cur_slot] = ld_val;
                        if (cur_slot == SL_EFL && mem_rdata[VM_BIT])
                            d.last = POP_FULL_N;
                    end
                    if (q.step == d.last) begin
                        d.ph   = ST_IDLE;
                        d.done = 1'b1;
                        if (q.pop) begin
                            d.eip = d.frame[SL_EIP];
                            d.efl = d.frame[SL_EFL];
                            d.esp = d.frame[SL_ESP];
                            d.cs  = d.frame[SL_CS][SEL_W-1:0];
                            d.ss  = d.frame[SL_SS][SEL_W-1:0];
                            d.vm  = d.frame[SL_EFL][VM_BIT];
                        end else begin
                            d.eip         = q.heip;
                            d.efl         = q.frame[SL_EFL];
                            d.efl[VM_BIT] = 1'b0;
                            d.esp         = sp_nxt;
                            d.cs          = q.hcs;
                            d.ss          = q.kss;
                            d.vm          = 1'b0;
                        end
                        d.es = q.ent_vm ? '0 : d.frame[SL_ES][SEL_W-1:0];
                        d.ds = q.ent_vm ? '0 : d.frame[SL_DS][SEL_W-1:0];
                        d.fs = q.ent_vm ? '0 : d.frame[SL_FS][SEL_W-1:0];
                        d.gs = q.ent_vm ? '0 : d.frame[SL_GS][SEL_W-1:0];
                    end else begin
                        d.step = q.step + 4'd1;
                    end
                end
            end
            default: d.ph = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req   = (q.ph == ST_RUN);
    assign mem_we    = !q.pop;
    assign mem_addr  = acc_addr;
    assign mem_wdata = wr_val;
    assign done      = q.done;
    assign fault     = q.fault;
    assign o_eip     = q.eip;
    assign o_eflags  = q.efl;
    assign o_esp     = q.esp;
    assign o_cs      = q.cs;
    assign o_ss      = q.ss;
    assign o_es      = q.es;
    assign o_ds      = q.ds;
    assign o_fs      = q.fs;
    assign o_gs      = q.gs;
    assign o_vm      = q.vm;
endmodule

// File: rtl/ifs_chk.sv
module ifs_chk #(
    parameter int DW    = 32,
    parameter int SEL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic             mem_err,
    input logic [DW-1:0]    mem_addr,
    input logic [DW-1:0]    mem_wdata,
    input logic             done,
    input logic             fault,
    input logic [DW-1:0]    o_eip,
    input logic [DW-1:0]    o_esp,
    input logic [SEL_W-1:0] o_cs
);
    localparam logic [DW-1:0] STEP_B = DW'(DW / 8);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R2
    push_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_we) |=>
            (!mem_req || (mem_we && mem_addr == $past(mem_addr) - STEP_B)));

    // R6
    pop_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we) |=>
            (!mem_req || (!mem_we && mem_addr == $past(mem_addr) + STEP_B)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!done && !mem_req && $stable(o_eip) && $stable(o_cs) && $stable(o_esp)));
endmodule

bind intr_frame_seq ifs_chk #(.DW(DW), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done),
    .fault     (fault),
    .o_eip     (o_eip),
    .o_esp     (o_esp),
    .o_cs      (o_cs)
);

// File: tb/intr_frame_seq_tb.sv
module intr_frame_seq_tb;
    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic start_entry = 0, start_iret = 0, from_vm = 0, has_err = 0;
    logic [31:0] err_code = 0, cur_eip = 0, cur_eflags = 0, cur_esp = 0, k_esp = 0, h_eip = 0;
    logic [15:0] cur_cs = 0, cur_ss = 0, cur_es = 0, cur_ds = 0, cur_fs = 0, cur_gs = 0, k_ss = 0, h_cs = 0;
    logic mem_req, mem_we, mem_ack = 0, mem_err = 0, done, fault, o_vm;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = 0, o_eip, o_eflags, o_esp;
    logic [15:0] o_cs, o_ss, o_es, o_ds, o_fs, o_gs;

    intr_frame_seq u_dut (.*);

    typedef struct {
        logic [31:0] addr;
        logic        we;
        logic [31:0] data;
        string       req;
    } acc_t;

    acc_t expq[$];
    logic [31:0] mem [logic [31:0]];
    int n_chk = 0, n_bad = 0;
    int wait_cycles = 0, wcnt = 0, acc_idx = 0, err_at = -1;
    int saw_done = 0, saw_fault = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 0; mem_err = 0; wcnt = 0;
        end else if (mem_ack || mem_err) begin
            mem_ack = 0; mem_err = 0;
        end else if (mem_req) begin
            if (wcnt < wait_cycles) wcnt++;
            else begin
                acc_t e;
                wcnt = 0;
                if (expq.size() == 0) begin
                    chk(0, "R11", "unexpected access addr", mem_addr, 32'hx);
                end else begin
                    e = expq.pop_front();
                    chk(mem_addr == e.addr, e.req, "access addr", mem_addr, e.addr);
                    chk(mem_we == e.we, e.req, "access dir", 32'(mem_we), 32'(e.we));
                    if (e.we) chk(mem_wdata == e.data, e.req, "write data", mem_wdata, e.data);
                end
                if (acc_idx == err_at) mem_err = 1;
                else begin
                    if (mem_we) mem[mem_addr] = mem_wdata;
                    else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                    mem_ack = 1;
                end
                acc_idx++;
            end
        end
    end

    task automatic expect_push(input logic [31:0] a, input logic [31:0] v, input string r);
        acc_t e;
        e.addr = a; e.we = 1'b1; e.data = v; e.req = r;
        expq.push_back(e);
    endtask

    task automatic expect_pop(input logic [31:0] a, input string r);
        acc_t e;
        e.addr = a; e.we = 1'b0; e.data = 0; e.req = r;
        expq.push_back(e);
    endtask

    // driver: computes expected entry frame and queues it
    task automatic plan_entry(input bit vm, input bit err, output logic [31:0] sp_end);
        logic [31:0] vals[10];
        logic [31:0] sp;
        int first, last;
        vals[0] = {16'h0, cur_gs}; vals[1] = {16'h0, cur_fs};
        vals[2] = {16'h0, cur_ds}; vals[3] = {16'h0, cur_es};
        vals[4] = {16'h0, cur_ss}; vals[5] = cur_esp; vals[6] = cur_eflags;
        vals[7] = {16'h0, cur_cs}; vals[8] = cur_eip; vals[9] = err_code;
        first = vm ? 0 : 4;
        last  = err ? 9 : 8;
        sp = k_esp;
        for (int i = first; i <= last; i++) begin
            sp = sp - 4;
            expect_push(sp, vals[i], i < 4 ? "R2" : (i == 9 ? "R3" : (vm ? "R2" : "R4")));
        end
        sp_end = sp;
    endtask

    task automatic plan_iret(input bit vm);
        int n = vm ? 9 : 5;
        for (int i = 0; i < n; i++) expect_pop(k_esp + 32'(4 * i), i < 5 ? "R6" : "R7");
    endtask

    task automatic pulse(input bit e, input bit r);
        @(negedge clk);
        start_entry = e; start_iret = r;
        @(negedge clk);
        start_entry = 0; start_iret = 0;
    endtask

    task automatic wait_end();
        saw_done = 0; saw_fault = 0;
        for (int i = 0; i < 2000 && !saw_done && !saw_fault; i++) begin
            @(negedge clk);
            if (done) saw_done = 1;
            if (fault) saw_fault = 1;
        end
    endtask

    task automatic check_regs(input string r, input logic [31:0] eip, input logic [31:0] efl,
                              input logic [31:0] esp, input logic [15:0] cs, input logic [15:0] ss,
                              input logic [15:0] es, input logic [15:0] ds, input logic [15:0] fs,
                              input logic [15:0] gs, input logic vm);
        chk(o_eip == eip, r, "o_eip", o_eip, eip);
        chk(o_eflags == efl, r, "o_eflags", o_eflags, efl);
        chk(o_esp == esp, r, "o_esp", o_esp, esp);
        chk(o_cs == cs, r, "o_cs", 32'(o_cs), 32'(cs));
        chk(o_ss == ss, r, "o_ss", 32'(o_ss), 32'(ss));
        chk(o_es == es && o_ds == ds, r, "o_es/o_ds", {o_es, o_ds}, {es, ds});
        chk(o_fs == fs && o_gs == gs, r, "o_fs/o_gs", {o_fs, o_gs}, {fs, gs});
        chk(o_vm == vm, r, "o_vm", 32'(o_vm), 32'(vm));
    endtask

    task automatic finish_op(input string r);
        chk(saw_done == 1, r, "done seen", 32'(saw_done), 1);
        @(negedge clk);
        chk(done == 0, "R9", "done width", 32'(done), 0);
        chk(expq.size() == 0, r, "leftover expected accesses", 32'(expq.size()), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] sp_end;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!done && !fault && !mem_req, "R1", "idle outputs", {done, fault, mem_req}, 0);
        check_regs("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // entry from V86 with error code, no wait states
        cur_eip = 32'h0000_1234; cur_cs = 16'h1111; cur_eflags = 32'h0002_3202;
        cur_esp = 32'h0000_FFF0; cur_ss = 16'h2222; cur_es = 16'h3333; cur_ds = 16'h4444;
        cur_fs = 16'h5555; cur_gs = 16'h6666; err_code = 32'hDEAD_0010;
        k_ss = 16'h0010; k_esp = 32'h0000_1000; h_cs = 16'h0008; h_eip = 32'hC000_1000;
        from_vm = 1; has_err = 1; wait_cycles = 0; acc_idx = 0;
        plan_entry(1, 1, sp_end);
        pulse(1, 0); wait_end(); finish_op("R2");
        check_regs("R5", 32'hC000_1000, 32'h0000_3202, sp_end, 16'h0008, 16'h0010, 0, 0, 0, 0, 0);

        // IRET back to V86: four extra pops
        k_esp = 32'h0000_0FDC; cur_es = 0; cur_ds = 0; cur_fs = 0; cur_gs = 0;
        wait_cycles = 1; acc_idx = 0;
        plan_iret(1);
        pulse(0, 1); wait_end(); finish_op("R7");
        check_regs("R7", 32'h0000_1234, 32'h0002_3202, 32'h0000_FFF0, 16'h1111, 16'h2222,
                   16'h3333, 16'h4444, 16'h5555, 16'h6666, 1);

        // entry not from V86, no error code, wait states
        cur_eip = 32'h0040_0100; cur_cs = 16'h001B; cur_eflags = 32'h0000_0246;
        cur_esp = 32'h7FFF_FF00; cur_ss = 16'h0023; cur_es = 16'h0023; cur_ds = 16'h002B;
        cur_fs = 16'h0033; cur_gs = 16'h003B; k_esp = 32'h0000_3000;
        from_vm = 0; has_err = 0; wait_cycles = 2; acc_idx = 0;
        plan_entry(0, 0, sp_end);
        pulse(1, 0); wait_end(); finish_op("R4");
        chk(sp_end == 32'h0000_2FEC, "R4", "frame bottom", sp_end, 32'h2FEC);
        check_regs("R5", 32'hC000_1000, 32'h0000_0246, 32'h0000_2FEC, 16'h0008, 16'h0010,
                   16'h0023, 16'h002B, 16'h0033, 16'h003B, 0);

        // IRET without VM, selector words carry junk upper halves
        mem[32'h2000] = 32'h0000_AAAA; mem[32'h2004] = 32'hFFFF_0033;
        mem[32'h2008] = 32'h0000_0202; mem[32'h200C] = 32'h0000_8000;
        mem[32'h2010] = 32'hABCD_003B;
        k_esp = 32'h0000_2000; cur_es = 16'h0007; cur_ds = 16'h0008; cur_fs = 16'h0009; cur_gs = 16'h000A;
        wait_cycles = 0; acc_idx = 0;
        plan_iret(0);
        pulse(0, 1); wait_end(); finish_op("R6");
        check_regs("R6", 32'h0000_AAAA, 32'h0000_0202, 32'h0000_8000, 16'h0033, 16'h003B,
                   16'h0007, 16'h0008, 16'h0009, 16'h000A, 0);

        // fault on third access: outputs keep previous values
        cur_eip = 32'h1111_1111; from_vm = 1; has_err = 1; k_esp = 32'h0000_4000;
        wait_cycles = 1; acc_idx = 0; err_at = 2;
        plan_entry(1, 1, sp_end);
        while (expq.size() > 3) void'(expq.pop_back());
        pulse(1, 0); wait_end();
        chk(saw_fault == 1 && saw_done == 0, "R10", "fault without done", {saw_fault[15:0], saw_done[15:0]}, 32'h0001_0000);
        @(negedge clk);
        chk(fault == 0, "R10", "fault width", 32'(fault), 0);
        repeat (4) @(negedge clk);
        chk(!mem_req, "R10", "no request after fault", 32'(mem_req), 0);
        chk(expq.size() == 0, "R10", "accesses before fault", 32'(expq.size()), 0);
        check_regs("R10", 32'h0000_AAAA, 32'h0000_0202, 32'h0000_8000, 16'h0033, 16'h003B,
                   16'h0007, 16'h0008, 16'h0009, 16'h000A, 0);
        err_at = -1;

        // both starts in one idle cycle: entry wins
        from_vm = 0; has_err = 1; k_esp = 32'h0000_5000; wait_cycles = 0; acc_idx = 0;
        plan_entry(0, 1, sp_end);
        pulse(1, 1); wait_end(); finish_op("R11");
        chk(o_esp == 32'h0000_4FE8, "R3", "esp below error code", o_esp, 32'h4FE8);
        chk(o_eip == h_eip, "R11", "entry performed", o_eip, h_eip);

        // return request while busy is ignored
        from_vm = 1; has_err = 0; k_esp = 32'h0000_6000; wait_cycles = 1; acc_idx = 0;
        plan_entry(1, 0, sp_end);
        pulse(1, 0);
        repeat (3) @(negedge clk);
        start_iret = 1; @(negedge clk); start_iret = 0;
        wait_end(); finish_op("R11");
        chk(o_esp == sp_end && o_gs == 0, "R11", "busy start ignored", o_esp, sp_end);
        repeat (5) @(negedge clk);
        chk(!mem_req, "R11", "no late request", 32'(mem_req), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule